// File: doc/BRIEF.md
# Periodic Schedule Enable Gate

This block decides when a host controller walks its periodic schedule. Software writes a single enable bit through a command-write strobe. The block does not act on that bit at once. It looks at the stored bit only when a micro-frame tick arrives with the low three bits of the 14-bit frame index at zero. That moment is a frame boundary, and it keeps split transactions that span micro-frame zero consistent. The result is the effective schedule state. It drives a traverse-enable output and a status bit that software polls to learn when its request has taken hold.

While the effective state is on, every micro-frame tick issues a one-cycle fetch request for the frame-list entry of the current frame. The fetch address joins the 4 KB-aligned list base with a word offset taken from the frame number. While the state is off, no fetch is issued and the base register has no effect. Software should change the enable bit only when it already equals the status bit. A write made at any other time raises a one-cycle protocol-violation flag.

Top module: `periodic_sched_gate`

## Requirements
- R1: While reset is high, and on the first cycle after it, status, traverse-enable, fetch request, fetch address and protocol-violation are all zero, whatever the other inputs are.
- R2: A tick with frame_index[2:0] == 0 loads the effective state from the stored enable bit. Status shows the new value in the cycle after that tick.
- R3: A tick with frame_index[2:0] != 0 leaves the effective state unchanged, even when the stored enable bit differs from it.
- R4: The traverse-enable output always equals the status output.
- R5: While the effective state is off, no fetch request is issued. The fetch address holds its last value, whatever list_base is.
- R6: While the effective state is on, each tick gives exactly one fetch_req pulse of one cycle, in the cycle after the tick.
- R7: The fetch address is {list_base[31:12], frame_index[12:3], 2'b00}. frame_index[13] and list_base[11:0] do not affect it.
- R8: The fetch address comes from the frame index and base present in the tick cycle, not from the values in the next cycle.
- R9: A command write made while the stored enable bit differs from status sets proto_violation for exactly the next cycle. A write made while they are equal does not set it.
- R10: A command write in the same cycle as a boundary tick is not seen by that boundary. The boundary uses the enable bit stored before the write.
- R11: On a boundary tick that turns the state on, the fetch for that same tick is issued. On a boundary tick that turns the state off, no fetch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the enable bit |
| cmd_enable | input | 1 | Enable value written when cmd_wr is high |
| uframe_tick | input | 1 | One-cycle pulse, one per micro-frame |
| frame_index | input | 14 | Current frame index; bits [2:0] select the micro-frame |
| list_base | input | 32 | Frame-list base address (4 KB aligned) |
| sched_status | output | 1 | Effective schedule state for polling |
| traverse_en | output | 1 | Schedule walk enable |
| fetch_req | output | 1 | One-cycle frame-list fetch request |
| fetch_addr | output | 32 | Byte address of the frame-list entry |
| proto_violation | output | 1 | Enable written while it differed from status |

## Verification
The assertions assume that uframe_tick is a single-cycle pulse. They also assume that frame_index and list_base describe the tick cycle, so the frame index may advance only after the tick. The bench drives each input set for exactly one cycle and advances the index on the cycle after each tick. It places writes both away from ticks and on the same cycle as a boundary tick. It also changes list_base while the schedule is off, to show that the base is ignored.

// File: rtl/psg_pkg.sv
package psg_pkg;

    localparam int unsigned PSG_IDX_W        = 14;
    localparam int unsigned PSG_ADDR_W       = 32;
    localparam int unsigned PSG_UFRAME_BITS  = 3;
    localparam int unsigned PSG_LIST_ENTRIES = 1024;
    localparam int unsigned PSG_PTR_BYTES    = 4;

    // Outcome of looking at one tick against the boundary rule.
    typedef struct packed {
        logic boundary;   // tick landed on micro-frame zero
        logic next_on;    // effective state after this cycle
        logic fire;       // issue a fetch for this tick
    } psg_gate_dec_t;

    // Registered fetch output.
    typedef struct packed {
        logic                  req;
        logic [PSG_ADDR_W-1:0] addr;
    } psg_fetch_t;

    // Command-side result.
    typedef enum logic [1:0] {
        PSG_CMD_IDLE  = 2'b00,
        PSG_CMD_CLEAN = 2'b01,
        PSG_CMD_BAD   = 2'b10
    } psg_cmd_kind_e;

    function automatic logic psg_is_boundary(input logic [PSG_UFRAME_BITS-1:0] uf);
        return (uf == '0);
    endfunction

    function automatic psg_cmd_kind_e psg_classify(input logic wr,
                                                   input logic en_q,
                                                   input logic status);
        if (!wr)
            return PSG_CMD_IDLE;
        else if (en_q != status)
            return PSG_CMD_BAD;
        else
            return PSG_CMD_CLEAN;
    endfunction

endpackage

// File: rtl/psg_cmd_reg.sv
module psg_cmd_reg
    import psg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic cmd_enable,
    input  logic status,
    output logic en_q,
    output logic violation
);

    psg_cmd_kind_e kind;

    always_comb begin
        kind = psg_classify(cmd_wr, en_q, status);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            violation <= 1'b0;
        end else begin
            if (cmd_wr)
                en_q <= cmd_enable;
            violation <= (kind == PSG_CMD_BAD);
        end
    end

endmodule

// File: rtl/psg_boundary_gate.sv
module psg_boundary_gate
    import psg_pkg::*;
#(
    parameter int unsigned UFRAME_BITS = PSG_UFRAME_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [UFRAME_BITS-1:0] uframe,
    input  logic                   en_q,
    output logic                   active,
    output logic                   fire
);

    psg_gate_dec_t dec;

    always_comb begin
        dec.boundary = tick && (uframe == '0);
        dec.next_on  = dec.boundary ? en_q : active;
        dec.fire     = tick && dec.next_on;
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else
            active <= dec.next_on;
    end

    assign fire = dec.fire;

endmodule

// File: rtl/psg_fetch_gen.sv
module psg_fetch_gen
    import psg_pkg::*;
#(
    parameter int unsigned ADDR_W       = PSG_ADDR_W,
    parameter int unsigned LIST_ENTRIES = PSG_LIST_ENTRIES,
    parameter int unsigned PTR_BYTES    = PSG_PTR_BYTES,
    localparam int unsigned ENT_W       = $clog2(LIST_ENTRIES),
    localparam int unsigned BYTE_SH     = $clog2(PTR_BYTES),
    localparam int unsigned ALIGN       = ENT_W + BYTE_SH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  logic [ENT_W-1:0]      entry,
    input  logic [ADDR_W-ALIGN-1:0] base_hi,
    output logic                  req,
    output logic [ADDR_W-1:0]     addr
);

    logic [ADDR_W-1:0] addr_next;

    generate
        if (BYTE_SH > 0) begin : g_word
            assign addr_next = {base_hi, entry, {BYTE_SH{1'b0}}};
        end else begin : g_byte
            assign addr_next = {base_hi, entry};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            addr <= '0;
        end else begin
            req <= fire;
            if (fire)
                addr <= addr_next;
        end
    end

endmodule

// File: rtl/periodic_sched_gate.sv
module periodic_sched_gate
    import psg_pkg::*;
#(
    parameter int unsigned IDX_W        = PSG_IDX_W,
    parameter int unsigned ADDR_W       = PSG_ADDR_W,
    parameter int unsigned UFRAME_BITS  = PSG_UFRAME_BITS,
    parameter int unsigned LIST_ENTRIES = PSG_LIST_ENTRIES,
    parameter int unsigned PTR_BYTES    = PSG_PTR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              cmd_enable,
    input  logic              uframe_tick,
    input  logic [IDX_W-1:0]  frame_index,
    input  logic [ADDR_W-1:0] list_base,
    output logic              sched_status,
    output logic              traverse_en,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              proto_violation
);

    localparam int unsigned ENT_W = $clog2(LIST_ENTRIES);
    localparam int unsigned ALIGN = ENT_W + $clog2(PTR_BYTES);

    logic en_q;
    logic active;
    logic fire;

    psg_cmd_reg u_cmd (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_enable (cmd_enable),
        .status     (active),
        .en_q       (en_q),
        .violation  (proto_violation)
    );

    psg_boundary_gate #(
        .UFRAME_BITS (UFRAME_BITS)
    ) u_gate (
        .clk    (clk),
        .rst    (rst),
        .tick   (uframe_tick),
        .uframe (frame_index[UFRAME_BITS-1:0]),
        .en_q   (en_q),
        .active (active),
        .fire   (fire)
    );

    psg_fetch_gen #(
        .ADDR_W       (ADDR_W),
        .LIST_ENTRIES (LIST_ENTRIES),
        .PTR_BYTES    (PTR_BYTES)
    ) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .entry   (frame_index[UFRAME_BITS+ENT_W-1:UFRAME_BITS]),
        .base_hi (list_base[ADDR_W-1:ALIGN]),
        .req     (fetch_req),
        .addr    (fetch_addr)
    );

    assign sched_status = active;
    assign traverse_en  = active;

endmodule

// File: rtl/periodic_sched_gate_chk.sv
module periodic_sched_gate_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr,
    input logic        uframe_tick,
    input logic [13:0] frame_index,
    input logic [31:0] list_base,
    input logic        en_q,
    input logic        sched_status,
    input logic        traverse_en,
    input logic        fetch_req,
    input logic [31:0] fetch_addr,
    input logic        proto_violation
);

    logic [31:0] want_addr;
    assign want_addr = (list_base & 32'hFFFF_F000)
                     | (((({18'd0, frame_index}) >> 3) & 32'h3FF) << 2);

    // R1: reset forces the outputs low on the following cycle
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!sched_status && !fetch_req && !proto_violation));

    // R2: a boundary tick copies the stored enable into status
    assert_boundary_load_R2: assert property (@(posedge clk) disable iff (rst)
        (uframe_tick && frame_index[2:0] == 3'd0) |=> (sched_status == $past(en_q)));

    // R3: no boundary, no change of status
    assert_hold_off_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        !(uframe_tick && frame_index[2:0] == 3'd0) |=> $stable(sched_status));

    // R4: traverse enable tracks status
    assert_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        traverse_en == sched_status);

    // R5: no fetch while the schedule is off
    assert_no_fetch_off_R5: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> sched_status);

    // R6: a fetch always answers a tick one cycle earlier
    assert_fetch_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> $past(uframe_tick));

    // R7 / R8: address built from the tick-cycle base and index
    assert_addr_form_R7: assert property (@(posedge clk) disable iff (rst)
        uframe_tick |=> (fetch_req -> (fetch_addr == $past(want_addr))));

    // R9: a violation pulse needs a write one cycle earlier
    assert_violation_cause_R9: assert property (@(posedge clk) disable iff (rst)
        proto_violation |-> $past(cmd_wr));

endmodule

bind periodic_sched_gate periodic_sched_gate_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_wr          (cmd_wr),
    .uframe_tick     (uframe_tick),
    .frame_index     (frame_index),
    .list_base       (list_base),
    .en_q            (en_q),
    .sched_status    (sched_status),
    .traverse_en     (traverse_en),
    .fetch_req       (fetch_req),
    .fetch_addr      (fetch_addr),
    .proto_violation (proto_violation)
);

// File: tb/tb_periodic_sched_gate.sv
`timescale 1ns/1ps
module tb_periodic_sched_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic        cmd_enable = 1'b0;
    logic        uframe_tick = 1'b0;
    logic [13:0] frame_index = '0;
    logic [31:0] list_base = '0;
    logic        sched_status, traverse_en, fetch_req, proto_violation;
    logic [31:0] fetch_addr;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    periodic_sched_gate dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_enable(cmd_enable),
        .uframe_tick(uframe_tick), .frame_index(frame_index), .list_base(list_base),
        .sched_status(sched_status), .traverse_en(traverse_en), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .proto_violation(proto_violation)
    );

    typedef struct {
        string       tag;
        logic        status;
        logic        req;
        logic [31:0] addr;
        logic        viol;
    } exp_t;

    exp_t sb[$];

    // reference state
    logic        m_en = 1'b0;
    logic        m_act = 1'b0;
    logic [31:0] m_addr = '0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus its expected outcome
    task automatic drive(string tag, logic wr, logic wdata, logic tick,
                         logic [13:0] idx, logic [31:0] base);
        exp_t e;
        logic nxt;
        @(negedge clk);
        cmd_wr      = wr;
        cmd_enable  = wdata;
        uframe_tick = tick;
        frame_index = idx;
        list_base   = base;
        e.viol = wr && (m_en != m_act);
        nxt = (tick && idx[2:0] == 3'd0) ? m_en : m_act;
        e.req = tick && nxt;
        if (e.req) m_addr = {base[31:12], idx[12:3], 2'b00};
        m_act = nxt;
        if (wr) m_en = wdata;
        e.status = m_act;
        e.addr = m_addr;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each cycle's outputs against the queue
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "status", {31'd0, sched_status}, {31'd0, e.status});
            check("R4", "traverse_en", {31'd0, traverse_en}, {31'd0, e.status});
            check(e.tag, "fetch_req", {31'd0, fetch_req}, {31'd0, e.req});
            check(e.tag, "fetch_addr", fetch_addr, e.addr);
            check(e.tag, "violation", {31'd0, proto_violation}, {31'd0, e.viol});
        end
    end

    initial begin
        #200000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset with enable written and ticks at a boundary
        cmd_wr = 1'b1; cmd_enable = 1'b1; uframe_tick = 1'b1;
        list_base = 32'hDEAD_B000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "status", {31'd0, sched_status}, 32'd0);
        check("R1", "fetch_req", {31'd0, fetch_req}, 32'd0);
        check("R1", "fetch_addr", fetch_addr, 32'd0);
        check("R1", "violation", {31'd0, proto_violation}, 32'd0);
        rst = 1'b0; cmd_wr = 1'b0; cmd_enable = 1'b0; uframe_tick = 1'b0;

        // R3: enable written, mid-frame ticks must not turn it on; R5: base ignored
        drive("R1", 1'b0, 1'b0, 1'b0, 14'd0, 32'h0);
        drive("R9", 1'b1, 1'b1, 1'b0, 14'd2, 32'h1111_1000);
        for (int i = 3; i < 8; i++)
            drive("R3", 1'b0, 1'b0, 1'b1, 14'(i), 32'h1000_0000 + 32'(i) * 32'h1000);
        drive("R5", 1'b0, 1'b0, 1'b0, 14'd7, 32'hFFFF_F000);

        // R2/R11/R7: boundary turns it on and fetches at once
        drive("R11", 1'b0, 1'b0, 1'b1, 14'd8, 32'hABCD_E123);
        // R8: index advances on the cycle after each tick
        drive("R8", 1'b0, 1'b0, 1'b0, 14'd9, 32'h5555_5000);
        drive("R6", 1'b0, 1'b0, 1'b1, 14'd9, 32'h1234_5FFF);
        drive("R8", 1'b0, 1'b0, 1'b0, 14'd10, 32'h0);
        drive("R6", 1'b0, 1'b0, 1'b1, 14'd10, 32'h1234_5000);
        drive("R6", 1'b0, 1'b0, 1'b1, 14'd11, 32'h8765_4000);
        // R7: top index bit and low base bits do not matter
        drive("R7", 1'b0, 1'b0, 1'b1, 14'h3FF9, 32'hC000_0FFF);
        drive("R7", 1'b0, 1'b0, 1'b1, 14'h1FFA, 32'h0000_1ABC);

        // R9: clean write, then a write while enable and status differ
        drive("R9", 1'b1, 1'b0, 1'b0, 14'h1FFA, 32'h0);
        drive("R9", 1'b1, 1'b1, 1'b0, 14'h1FFA, 32'h0);
        drive("R9", 1'b0, 1'b0, 1'b0, 14'h1FFA, 32'h0);
        drive("R9", 1'b1, 1'b0, 1'b0, 14'h1FFA, 32'h0);
        // R3: stored enable is off but the mid-frame tick keeps the walk going
        drive("R3", 1'b0, 1'b0, 1'b1, 14'd13, 32'h7700_0000);
        // R2/R11: boundary turns it off, no fetch
        drive("R11", 1'b0, 1'b0, 1'b1, 14'd16, 32'h7700_0000);
        drive("R5", 1'b0, 1'b0, 1'b1, 14'd17, 32'h9900_0000);

        // R10: write on the same cycle as a boundary tick is too late
        drive("R10", 1'b1, 1'b1, 1'b1, 14'd24, 32'h4400_0000);
        drive("R10", 1'b0, 1'b0, 1'b1, 14'd25, 32'h4400_0000);
        drive("R2", 1'b0, 1'b0, 1'b1, 14'd32, 32'h4400_0000);
        drive("R6", 1'b0, 1'b0, 1'b0, 14'd33, 32'h4400_0000);
        drive("R6", 1'b0, 1'b0, 1'b0, 14'd33, 32'h4400_0000);

        // R1: reset again while enabled
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", "status after rerun", {31'd0, sched_status}, 32'd0);
        check("R1", "fetch_addr after rerun", fetch_addr, 32'd0);
        rst = 1'b0;
        m_en = 1'b0; m_act = 1'b0; m_addr = '0;
        drive("R2", 1'b0, 1'b0, 1'b1, 14'd40, 32'h3300_0000);
        drive("R2", 1'b0, 1'b0, 1'b0, 14'd41, 32'h3300_0000);
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule